// File: doc/BRIEF.md
# Bit-Field Read-Modify-Write Engine

This block updates one bit field inside a word of a 32-bit register space without disturbing the other bits of that word. A requester hands it a base address, a packed field descriptor and a new value, then pulses a start strobe. The engine reads the target word, clears only the bits that the descriptor names, merges the new value in at the right position, and writes the word back.

The descriptor packs three items into one 32-bit word. The engine builds the field mask from the width and offset itself, so the requester never supplies a mask. A descriptor that names an empty field, or a field that runs past the top of the word, is refused: the engine raises an error and touches no memory.

The memory side is a simple single-outstanding port with separate read and write request/acknowledge handshakes. The command side is a start strobe with busy and done indications.

Top module: `field_rmw_writer`

## Requirements
- R1: Descriptor layout: bits 31:16 are the word offset, bits 15:8 the field width and bits 7:0 the field's lowest bit position. The target address is the base address plus the zero-extended word offset, and both the read and the write go to that address.
- R2: A valid command issues exactly one read and then exactly one write. The write request is raised only after the read acknowledge, and the two requests are never high together.
- R3: Every bit of the written word outside the field range [lsb, lsb+width-1] equals the same bit of the word that was read.
- R4: The field bits of the written word hold the low `width` bits of the value, shifted up by lsb. Value bits at or above `width` are discarded.
- R5: Width 32 with lsb 0 replaces the whole word with the value, with no shift artefact.
- R6: A width of 0, or lsb+width greater than 32, makes done and error pulse together two cycles after start is accepted. No read or write is issued in that case, and memory is unchanged.
- R7: done is a one-cycle pulse in the cycle after the write acknowledge is sampled. busy is high from the cycle after start is accepted through the last cycle before done, and it is low in the done cycle.
- R8: A start pulse while busy is high is ignored: the running command completes unchanged, and no second command is started.
- R9: After reset, busy, done, error, rd_req and wr_req are all low.
- R10: A read or write request, once raised, stays high until its acknowledge is sampled, and drops in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, accepted when busy is low |
| base_addr | input | ADDR_W | Base address of the register space |
| descriptor | input | 32 | Packed word offset, field width and field lsb |
| value | input | DATA_W | New field value (truncated to width) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Pulses with done when the descriptor was refused |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge, with rd_data valid |
| rd_data | input | DATA_W | Read data |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | Write acknowledge |

## Verification
On every cycle, the assertions check the handshake discipline: the two requests never overlap, and each request is held until its acknowledge. They also check that done is a single pulse that follows either a write acknowledge or a refused descriptor, that busy only falls together with done, and that a start during busy leaves the latched command unchanged. They further check that the word being written keeps every bit outside the mask and carries the aligned value inside it. Only the bench scenarios can show that the address arithmetic, the truncation of the value, the full-word and top-edge fields, and the refusal of bad descriptors produce the right word in the modelled memory, with memory left untouched when the descriptor is refused.

// File: rtl/fw_pkg.sv
package fw_pkg;
  localparam int DESC_W  = 32;
  localparam int OFS_W   = 16;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic [OFS_W-1:0]   word_ofs;
    logic [FIELD_W-1:0] width;
    logic [FIELD_W-1:0] lsb;
  } fw_desc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } fw_state_e;
endpackage

// File: rtl/fw_field_decode.sv
module fw_field_decode
  import fw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  fw_desc_t          desc,
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] value,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] ins_bits,
  output logic              valid
);
  localparam int SUM_W = FIELD_W + 1;
  localparam int SH_W  = $clog2(DATA_W);
  localparam logic [SUM_W-1:0] TOP = SUM_W'(DATA_W);

  logic [SUM_W-1:0]  lsb_ext;
  logic [SUM_W-1:0]  wid_ext;
  logic [SUM_W-1:0]  end_ext;
  logic [DATA_W-1:0] keep_lo;
  logic [DATA_W-1:0] trunc;
  logic [DATA_W-1:0] shifted;

  assign lsb_ext = {1'b0, desc.lsb};
  assign wid_ext = {1'b0, desc.width};
  assign end_ext = lsb_ext + wid_ext;

  // the field is refused when empty or when it spills over the top bit
  assign valid = (desc.width != '0) && (end_ext <= TOP);

  assign addr = base + ADDR_W'(desc.word_ofs);

  // per-bit range compare: no shift by the full word width anywhere
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
    assign keep_lo[i]  = (IDX < wid_ext);
    assign clr_mask[i] = (IDX >= lsb_ext) && (IDX < end_ext);
  end

  assign trunc    = value & keep_lo;
  assign shifted  = trunc << desc.lsb[SH_W-1:0];
  assign ins_bits = shifted & clr_mask;
endmodule

// File: rtl/fw_merge.sv
module fw_merge #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [DATA_W-1:0] ins_bits,
  output logic [DATA_W-1:0] new_word
);
  assign new_word = (old_word & ~clr_mask) | ins_bits;
endmodule

// File: rtl/fw_ctrl.sv
module fw_ctrl
  import fw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic valid,
  input  logic rd_ack,
  input  logic wr_ack,
  output logic load_cmd,
  output logic load_plan,
  output logic load_wdata,
  output logic busy,
  output logic done,
  output logic error,
  output logic rd_req,
  output logic wr_req
);
  fw_state_e state;

  assign load_cmd   = (state == ST_IDLE) && start;
  assign load_plan  = (state == ST_CHECK);
  assign load_wdata = (state == ST_READ) && rd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
      rd_req <= 1'b0;
      wr_req <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_CHECK;
          busy  <= 1'b1;
        end
        ST_CHECK: if (valid) begin
          state  <= ST_READ;
          rd_req <= 1'b1;
        end else begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
          error <= 1'b1;
        end
        ST_READ: if (rd_ack) begin
          rd_req <= 1'b0;
          wr_req <= 1'b1;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (wr_ack) begin
          wr_req <= 1'b0;
          busy   <= 1'b0;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_req_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req);
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    wr_req && !wr_ack |=> wr_req);
  p_rd_drop_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ack |=> !rd_req && wr_req);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_src_r7: assert property (@(posedge clk) disable iff (rst)
    done && !error |-> $past(wr_req && wr_ack));
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    error |-> done && !rd_req && !wr_req && $past(!rd_req && !wr_req));
endmodule

// File: rtl/field_rmw_writer.sv
module field_rmw_writer
  import fw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DESC_W-1:0] descriptor,
  input  logic [DATA_W-1:0] value,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack
);
  fw_desc_t          desc_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] value_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] ins_q;
  logic [DATA_W-1:0] old_q;
  logic [DATA_W-1:0] wdata_q;

  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_mask;
  logic [DATA_W-1:0] dec_ins;
  logic              dec_valid;
  logic [DATA_W-1:0] merged;
  logic              load_cmd;
  logic              load_plan;
  logic              load_wdata;

  fw_field_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .desc     (desc_q),
    .base     (base_q),
    .value    (value_q),
    .addr     (dec_addr),
    .clr_mask (dec_mask),
    .ins_bits (dec_ins),
    .valid    (dec_valid)
  );

  fw_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word (rd_data),
    .clr_mask (mask_q),
    .ins_bits (ins_q),
    .new_word (merged)
  );

  fw_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .valid      (dec_valid),
    .rd_ack     (rd_ack),
    .wr_ack     (wr_ack),
    .load_cmd   (load_cmd),
    .load_plan  (load_plan),
    .load_wdata (load_wdata),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .rd_req     (rd_req),
    .wr_req     (wr_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_q  <= '0;
      base_q  <= '0;
      value_q <= '0;
      addr_q  <= '0;
      mask_q  <= '0;
      ins_q   <= '0;
      old_q   <= '0;
      wdata_q <= '0;
    end else begin
      if (load_cmd) begin
        desc_q  <= fw_desc_t'(descriptor);
        base_q  <= base_addr;
        value_q <= value;
      end
      if (load_plan) begin
        addr_q <= dec_addr;
        mask_q <= dec_mask;
        ins_q  <= dec_ins;
      end
      if (load_wdata) begin
        old_q   <= rd_data;
        wdata_q <= merged;
      end
    end
  end

  assign rd_addr = addr_q;
  assign wr_addr = addr_q;
  assign wr_data = wdata_q;

  p_keep_outside_r3: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> ((wr_data ^ old_q) & ~mask_q) == '0);
  p_field_bits_r4: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (wr_data & mask_q) == ins_q);
  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(desc_q) && $stable(value_q) && $stable(base_q));
  p_mask_nonempty_r1: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> mask_q != '0);
endmodule

// File: tb/field_rmw_writer_tb_top.sv
module field_rmw_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [31:0] descriptor = '0;
  logic [31:0] value = '0;
  logic        busy, done, error, rd_req, wr_req;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic        rd_ack = 1'b0;
  logic        wr_ack = 1'b0;
  logic [31:0] rd_data = '0;

  always #4 clk = ~clk;

  field_rmw_writer #(.DATA_W(32), .ADDR_W(32)) dut_i (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .descriptor(descriptor), .value(value), .busy(busy), .done(done),
    .error(error), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack)
  );

  logic [31:0] mem [logic [31:0]];
  int checks = 0, fails = 0, cyc = 0;
  int rd_lat = 0, wr_lat = 0, rd_wait = 0, wr_wait = 0;
  int rd_count = 0, wr_count = 0, rd_cyc = 0, wr_cyc = 0;
  logic [31:0] last_rd, last_wr;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // behavioural memory responder: acks one cycle, after a set latency
  initial forever begin
    @(negedge clk);
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (rd_wait >= rd_lat) begin
        rd_data = peek(rd_addr); rd_ack = 1'b1; rd_count++;
        last_rd = rd_addr; rd_cyc = cyc; rd_wait = 0;
      end else rd_wait++;
    end
    if (wr_ack) wr_ack = 1'b0;
    else if (wr_req) begin
      if (wr_wait >= wr_lat) begin
        mem[wr_addr] = wr_data; wr_ack = 1'b1; wr_count++;
        last_wr = wr_addr; wr_cyc = cyc; wr_wait = 0;
      end else wr_wait++;
    end
  end

  task automatic run_op(input logic [31:0] base, input logic [31:0] desc,
                        input logic [31:0] val, input int rl, input int wl,
                        input bit intrude, input string tag);
    int w, o, n;
    bit ok, seen, busy_bad;
    logic [31:0] addr, old, exp, iaddr, iold;
    w = int'(desc[15:8]); o = int'(desc[7:0]);
    addr = base + {16'h0, desc[31:16]};
    ok = (w != 0) && (o + w <= 32);
    old = peek(addr); exp = old;
    if (ok) for (int i = 0; i < 32; i++)
      if (i >= o && i < o + w) exp[i] = val[i - o];
    iaddr = addr + 32'h40; iold = peek(iaddr);
    rd_lat = rl; wr_lat = wl; rd_count = 0; wr_count = 0;
    @(negedge clk);
    base_addr = base; descriptor = desc; value = val; start = 1'b1;
    @(negedge clk);
    start = 1'b0; descriptor = 32'hFFFF_FFFF; value = '0;
    seen = 0; busy_bad = 0; n = 0;
    while (!seen && n < 60) begin
      if (done) seen = 1;
      else begin
        if (!busy) busy_bad = 1;
        if (intrude && n == 1) begin
          start = 1'b1; base_addr = base + 32'h40; descriptor = 32'h0000_2000;
        end else start = 1'b0;
        @(negedge clk); n++;
      end
    end
    start = 1'b0;
    check(seen, "R7 done seen", {31'h0, seen}, 32'h1);
    check(!busy_bad && !busy, "R7 busy window", {31'h0, busy}, 32'h0);
    check(error == !ok, "R6 error flag", {31'h0, error}, {31'h0, !ok});
    if (ok) begin
      check(rd_count == 1 && last_rd == addr, "R1 read address", last_rd, addr);
      check(wr_count == 1 && last_wr == addr, "R1 write address", last_wr, addr);
      check(rd_cyc < wr_cyc, "R2 read before write", rd_cyc, wr_cyc);
      check(peek(addr) == exp, tag, peek(addr), exp);
    end else begin
      check(rd_count == 0 && wr_count == 0, "R6 no access",
            rd_count + wr_count, 0);
      check(peek(addr) == old, "R6 memory unchanged", peek(addr), old);
    end
    if (intrude)
      check(peek(iaddr) == iold && wr_count == 1, "R8 start ignored",
            peek(iaddr), iold);
    @(negedge clk);
    check(!done, "R7 done one cycle", {31'h0, done}, 32'h0);
  endtask

  initial begin
    mem[32'h104] = 32'hFFFF_FFFF;
    mem[32'h200] = 32'hDEAD_BEEF;
    mem[32'h300] = 32'h0;
    mem[32'h308] = 32'h5555_5555;
    mem[32'h1FFF0] = 32'hA5A5_A5A5;
    mem[32'h410] = 32'h1234_5678;
    mem[32'h450] = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    check(!busy && !done && !error && !rd_req && !wr_req, "R9 reset state",
          {27'h0, busy, done, error, rd_req, wr_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !rd_req && !wr_req, "R9 idle after reset",
          {29'h0, busy, rd_req, wr_req}, 32'h0);
    // width 8 at lsb 4, value above width must be dropped
    run_op(32'h100, 32'h0004_0804, 32'h0000_0ABC, 0, 0, 0, "R4 truncated field");
    run_op(32'h200, 32'h0000_2000, 32'h1234_5678, 1, 2, 0, "R5 full word");
    run_op(32'h300, 32'h0000_011F, 32'h0000_0003, 2, 0, 0, "R4 top bit");
    run_op(32'h300, 32'h0008_051B, 32'h0000_001A, 3, 3, 0, "R3 top-edge field");
    run_op(32'h10000, 32'hFFF0_0C08, 32'hFFFF_F123, 0, 1, 0, "R1 large offset");
    run_op(32'h300, 32'h0000_0004, 32'h0000_00FF, 0, 0, 0, "R6 zero width");
    run_op(32'h300, 32'h0000_0819, 32'h0000_00FF, 0, 0, 0, "R6 overflow");
    run_op(32'h300, 32'h0000_C800, 32'h0000_00FF, 0, 0, 0, "R6 huge width");
    run_op(32'h410, 32'h0000_1008, 32'h0000_BEEF, 4, 4, 1, "R3 with intrusion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule